// File: doc/BRIEF.md
# Character-Row Video Timing Generator

This core produces the raster timing for a character-based display. A horizontal counter steps once per character clock across each scan line. A scan-line counter steps through the lines that make up one character row, and a row counter steps through the rows of the frame. From these three counters the core derives a display-enable strobe, horizontal and vertical sync, and the column, row and scan-line addresses. A character generator uses these addresses to fetch glyph data.

Every timing value is an input port, so a register block elsewhere in the chip can program the core. The frame height is a whole number of character rows plus a separate count of extra adjust lines, which run after the last row. The vertical sync start is set in whole rows. Its length is set in scan lines and may cross row boundaries. The rising edge of vsync is deliberately placed one or two character clocks before the scan line where vsync nominally begins. This lets software that polls or takes interrupts on vsync be aligned exactly to the beam. A mode input selects whether each clock carries one or two characters.

All outputs are registered. They change in step with the internal counters, so every output describes the same raster position on every clock.

Top module: `crt_timing_core`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, the outputs describe the frame origin: `col_addr`, `row_addr` and `scan_addr` are 0.
- R2: The horizontal position advances by one per clock, from 0 to `cfg_h_total`-1, then returns to 0 and starts the next scan line. With `cfg_dbl` low, `col_addr` equals the horizontal position.
- R3: `de` is high exactly when the horizontal position is below `cfg_h_disp`, `row_addr` is below `cfg_v_disp`, and the line is not an adjust line.
- R4: `hsync` is high exactly when the horizontal position p satisfies `cfg_hs_start` <= p < `cfg_hs_start`+`cfg_hs_width`.
- R5: `scan_addr` counts 0 to `cfg_row_lines`-1 within each row. `row_addr` then increments. After row `cfg_v_rows`-1, the row count wraps to 0 if `cfg_v_adj` is 0.
- R6: If `cfg_v_adj` is nonzero, `cfg_v_adj` adjust lines follow the last row. During these lines `row_addr` holds at `cfg_v_rows`-1, `scan_addr` counts 0 to `cfg_v_adj`-1, and `de` is low. The frame origin follows.
- R7: The nominal vsync interval begins at scan line 0 of row `cfg_vs_row` and covers `cfg_vs_lines` whole scan lines. `vsync` is high throughout it and falls at horizontal position 0 of the first line after it.
- R8: With `cfg_vs_two_early` = 0, `vsync` rises at horizontal position `cfg_h_total`-1 of the scan line before the nominal start.
- R9: With `cfg_vs_two_early` = 1, `vsync` rises at horizontal position `cfg_h_total`-2 of that scan line. The falling edge is unchanged.
- R10: With `cfg_vs_lines` = 0, `vsync` stays low for the whole frame, including the early-rise window.
- R11: With `cfg_dbl` high, each clock carries two characters and `col_addr` equals twice the horizontal position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset to the frame origin |
| cfg_h_total | input | HW | Clocks per scan line |
| cfg_h_disp | input | HW | Displayed clocks per scan line |
| cfg_hs_start | input | HW | Horizontal position where hsync starts |
| cfg_hs_width | input | HW | Hsync length in clocks |
| cfg_v_rows | input | RW | Character rows per frame, excluding adjust lines |
| cfg_v_disp | input | RW | Displayed character rows |
| cfg_row_lines | input | SW | Scan lines per character row |
| cfg_v_adj | input | SW | Extra adjust scan lines at the end of the frame |
| cfg_vs_row | input | RW | Row whose first scan line starts vsync |
| cfg_vs_lines | input | SW | Vsync length in scan lines |
| cfg_dbl | input | 1 | Two characters per clock |
| cfg_vs_two_early | input | 1 | Vsync rises two clocks early instead of one |
| de | output | 1 | Display enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| col_addr | output | HW+1 | Index of the first character of the current clock |
| row_addr | output | RW | Current character row |
| scan_addr | output | SW | Scan line within the row, or adjust line index |

## Verification
The bench runs four configurations, each for two full frames, and compares every output on every clock against a position computed from the clock count. The first configuration has adjust lines and a single-clock lead, so it separates the row wrap from the adjust path and checks the one-clock rise. The second has no adjust lines, vsync at row 0, a two-clock lead and double-width columns, so it exercises the lead across the frame wrap and the column scaling. The third sets a zero vsync length, which separates a correct gate from a stray early-rise pulse. The fourth is the 25-of-50-row layout with 8-line rows and a 16-line vsync that starts at row 37, where vsync crosses row boundaries.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int unsigned CRT_HW_DEF = 8;
  localparam int unsigned CRT_RW_DEF = 7;
  localparam int unsigned CRT_SW_DEF = 5;

  typedef enum logic {
    VS_LEAD_ONE = 1'b0,
    VS_LEAD_TWO = 1'b1
  } vs_lead_e;
endpackage

// File: rtl/crt_line_step.sv
module crt_line_step #(
  parameter int unsigned RW = 7,
  parameter int unsigned SW = 5
) (
  input  logic [RW-1:0] row,
  input  logic [SW-1:0] scan,
  input  logic          adj,
  input  logic [RW-1:0] cfg_v_rows,
  input  logic [SW-1:0] cfg_row_lines,
  input  logic [SW-1:0] cfg_v_adj,
  output logic [RW-1:0] row_nx,
  output logic [SW-1:0] scan_nx,
  output logic          adj_nx
);
  logic last_scan;
  logic last_row;
  logic last_adj;

  always_comb begin
    last_scan = (scan == cfg_row_lines - 1'b1);
    last_row  = (row == cfg_v_rows - 1'b1);
    last_adj  = (scan == cfg_v_adj - 1'b1);
    row_nx    = row;
    scan_nx   = scan + 1'b1;
    adj_nx    = adj;
    if (adj) begin
      if (last_adj) begin
        row_nx  = '0;
        scan_nx = '0;
        adj_nx  = 1'b0;
      end
    end else if (last_scan) begin
      scan_nx = '0;
      if (!last_row) begin
        row_nx = row + 1'b1;
      end else if (cfg_v_adj == '0) begin
        row_nx = '0;
      end else begin
        adj_nx = 1'b1;
      end
    end
  end
endmodule

// File: rtl/crt_hcount.sv
module crt_hcount #(
  parameter int unsigned HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] cfg_h_total,
  output logic [HW-1:0] h_q,
  output logic [HW-1:0] h_n,
  output logic          line_end
);
  always_comb begin
    line_end = !rst && (h_q == cfg_h_total - 1'b1);
    if (rst || line_end) h_n = '0;
    else                 h_n = h_q + 1'b1;
  end

  always_ff @(posedge clk) h_q <= h_n;

  p_h_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    h_q < cfg_h_total);
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (h_q == '0));
endmodule

// File: rtl/crt_vcount.sv
module crt_vcount #(
  parameter int unsigned RW = 7,
  parameter int unsigned SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_end,
  input  logic [RW-1:0] cfg_v_rows,
  input  logic [SW-1:0] cfg_row_lines,
  input  logic [SW-1:0] cfg_v_adj,
  input  logic [RW-1:0] cfg_vs_row,
  input  logic [SW-1:0] cfg_vs_lines,
  output logic [RW-1:0] row_n,
  output logic [SW-1:0] scan_n,
  output logic          adj_n,
  output logic [SW-1:0] vscnt_n
);
  logic [RW-1:0] row_q;
  logic [SW-1:0] scan_q;
  logic          adj_q;
  logic [SW-1:0] vscnt_q;
  logic [RW-1:0] st_row;
  logic [SW-1:0] st_scan;
  logic          st_adj;
  logic          start_n;
  logic [SW-1:0] vs_dec;

  crt_line_step #(.RW(RW), .SW(SW)) u_step (
    .row(row_q), .scan(scan_q), .adj(adj_q),
    .cfg_v_rows(cfg_v_rows), .cfg_row_lines(cfg_row_lines), .cfg_v_adj(cfg_v_adj),
    .row_nx(st_row), .scan_nx(st_scan), .adj_nx(st_adj)
  );

  always_comb begin
    if (rst) begin
      row_n = '0; scan_n = '0; adj_n = 1'b0;
    end else if (line_end) begin
      row_n = st_row; scan_n = st_scan; adj_n = st_adj;
    end else begin
      row_n = row_q; scan_n = scan_q; adj_n = adj_q;
    end
    start_n = (row_n == cfg_vs_row) && (scan_n == '0) && !adj_n;
    vs_dec  = (rst || vscnt_q == '0) ? '0 : vscnt_q - 1'b1;
    if (rst || line_end) vscnt_n = start_n ? cfg_vs_lines : vs_dec;
    else                 vscnt_n = vscnt_q;
  end

  always_ff @(posedge clk) begin
    row_q   <= row_n;
    scan_q  <= scan_n;
    adj_q   <= adj_n;
    vscnt_q <= vscnt_n;
  end

  p_scan_bound_r5: assert property (@(posedge clk) disable iff (rst)
    !adj_q |-> (scan_q < cfg_row_lines));
  p_adj_row_held_r6: assert property (@(posedge clk) disable iff (rst)
    adj_q |-> (row_q == cfg_v_rows - 1'b1) && (scan_q < cfg_v_adj));
endmodule

// File: rtl/crt_outstage.sv
module crt_outstage
  import crt_pkg::*;
#(
  parameter int unsigned HW = 8,
  parameter int unsigned RW = 7,
  parameter int unsigned SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_n,
  input  logic [RW-1:0] row_n,
  input  logic [SW-1:0] scan_n,
  input  logic          adj_n,
  input  logic [SW-1:0] vscnt_n,
  input  logic [HW-1:0] cfg_h_total,
  input  logic [HW-1:0] cfg_h_disp,
  input  logic [HW-1:0] cfg_hs_start,
  input  logic [HW-1:0] cfg_hs_width,
  input  logic [RW-1:0] cfg_v_rows,
  input  logic [RW-1:0] cfg_v_disp,
  input  logic [SW-1:0] cfg_row_lines,
  input  logic [SW-1:0] cfg_v_adj,
  input  logic [RW-1:0] cfg_vs_row,
  input  logic [SW-1:0] cfg_vs_lines,
  input  logic          cfg_dbl,
  input  vs_lead_e      vs_lead,
  output logic          de_q,
  output logic          hsync_q,
  output logic          vsync_q,
  output logic [HW:0]   col_q,
  output logic [RW-1:0] row_q,
  output logic [SW-1:0] scan_q
);
  localparam logic [HW:0] LEAD_ONE = (HW+1)'(1);
  localparam logic [HW:0] LEAD_TWO = (HW+1)'(2);

  logic [RW-1:0] la_row;
  logic [SW-1:0] la_scan;
  logic          la_adj;
  logic [HW:0]   h_ext;
  logic [HW:0]   hs_lo;
  logic [HW:0]   hs_hi;
  logic [HW:0]   lead;
  logic          in_lead;
  logic          ahead_start;

  // Position of the scan line after the one being entered
  crt_line_step #(.RW(RW), .SW(SW)) u_ahead (
    .row(row_n), .scan(scan_n), .adj(adj_n),
    .cfg_v_rows(cfg_v_rows), .cfg_row_lines(cfg_row_lines), .cfg_v_adj(cfg_v_adj),
    .row_nx(la_row), .scan_nx(la_scan), .adj_nx(la_adj)
  );

  always_comb begin
    h_ext       = {1'b0, h_n};
    hs_lo       = {1'b0, cfg_hs_start};
    hs_hi       = hs_lo + {1'b0, cfg_hs_width};
    lead        = (vs_lead == VS_LEAD_TWO) ? LEAD_TWO : LEAD_ONE;
    in_lead     = (h_ext + lead) >= {1'b0, cfg_h_total};
    ahead_start = (la_row == cfg_vs_row) && (la_scan == '0) && !la_adj;
  end

  always_ff @(posedge clk) begin
    de_q    <= (h_n < cfg_h_disp) && (row_n < cfg_v_disp) && !adj_n;
    hsync_q <= (h_ext >= hs_lo) && (h_ext < hs_hi);
    vsync_q <= (vscnt_n != '0) || (in_lead && ahead_start && (cfg_vs_lines != '0));
    col_q   <= cfg_dbl ? {h_n, 1'b0} : {1'b0, h_n};
    row_q   <= row_n;
    scan_q  <= scan_n;
  end

  p_de_rows_r3: assert property (@(posedge clk) disable iff (rst)
    de_q |-> (row_q < cfg_v_disp));
  p_no_vs_when_empty_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_vs_lines == '0) |-> !vsync_q);
endmodule

// File: rtl/crt_timing_core.sv
module crt_timing_core
  import crt_pkg::*;
#(
  parameter int unsigned HW = CRT_HW_DEF,
  parameter int unsigned RW = CRT_RW_DEF,
  parameter int unsigned SW = CRT_SW_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] cfg_h_total,
  input  logic [HW-1:0] cfg_h_disp,
  input  logic [HW-1:0] cfg_hs_start,
  input  logic [HW-1:0] cfg_hs_width,
  input  logic [RW-1:0] cfg_v_rows,
  input  logic [RW-1:0] cfg_v_disp,
  input  logic [SW-1:0] cfg_row_lines,
  input  logic [SW-1:0] cfg_v_adj,
  input  logic [RW-1:0] cfg_vs_row,
  input  logic [SW-1:0] cfg_vs_lines,
  input  logic          cfg_dbl,
  input  logic          cfg_vs_two_early,
  output logic          de,
  output logic          hsync,
  output logic          vsync,
  output logic [HW:0]   col_addr,
  output logic [RW-1:0] row_addr,
  output logic [SW-1:0] scan_addr
);
  logic [HW-1:0] h_q;
  logic [HW-1:0] h_n;
  logic          line_end;
  logic [RW-1:0] row_n;
  logic [SW-1:0] scan_n;
  logic          adj_n;
  logic [SW-1:0] vscnt_n;
  vs_lead_e      vs_lead;

  assign vs_lead = cfg_vs_two_early ? VS_LEAD_TWO : VS_LEAD_ONE;

  crt_hcount #(.HW(HW)) u_h (
    .clk(clk), .rst(rst), .cfg_h_total(cfg_h_total),
    .h_q(h_q), .h_n(h_n), .line_end(line_end)
  );

  crt_vcount #(.RW(RW), .SW(SW)) u_v (
    .clk(clk), .rst(rst), .line_end(line_end),
    .cfg_v_rows(cfg_v_rows), .cfg_row_lines(cfg_row_lines), .cfg_v_adj(cfg_v_adj),
    .cfg_vs_row(cfg_vs_row), .cfg_vs_lines(cfg_vs_lines),
    .row_n(row_n), .scan_n(scan_n), .adj_n(adj_n), .vscnt_n(vscnt_n)
  );

  crt_outstage #(.HW(HW), .RW(RW), .SW(SW)) u_out (
    .clk(clk), .rst(rst), .h_n(h_n), .row_n(row_n), .scan_n(scan_n),
    .adj_n(adj_n), .vscnt_n(vscnt_n),
    .cfg_h_total(cfg_h_total), .cfg_h_disp(cfg_h_disp),
    .cfg_hs_start(cfg_hs_start), .cfg_hs_width(cfg_hs_width),
    .cfg_v_rows(cfg_v_rows), .cfg_v_disp(cfg_v_disp),
    .cfg_row_lines(cfg_row_lines), .cfg_v_adj(cfg_v_adj),
    .cfg_vs_row(cfg_vs_row), .cfg_vs_lines(cfg_vs_lines),
    .cfg_dbl(cfg_dbl), .vs_lead(vs_lead),
    .de_q(de), .hsync_q(hsync), .vsync_q(vsync),
    .col_q(col_addr), .row_q(row_addr), .scan_q(scan_addr)
  );

  // R8 / R9: a rising vsync edge only ever falls inside the lead window
  p_vs_rise_lead_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> (({1'b0, h_q} + (cfg_vs_two_early ? (HW+1)'(2) : (HW+1)'(1)))
                      >= {1'b0, cfg_h_total}));
  p_vs_fall_line_start_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync) |-> (h_q == '0));
endmodule

// File: tb/tb_crt_timing_core.sv
module tb_crt_timing_core;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 8;
  localparam int RW = 7;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [HW-1:0] cfg_h_total, cfg_h_disp, cfg_hs_start, cfg_hs_width;
  logic [RW-1:0] cfg_v_rows, cfg_v_disp, cfg_vs_row;
  logic [SW-1:0] cfg_row_lines, cfg_v_adj, cfg_vs_lines;
  logic          cfg_dbl, cfg_vs_two_early;
  logic          de, hsync, vsync;
  logic [HW:0]   col_addr;
  logic [RW-1:0] row_addr;
  logic [SW-1:0] scan_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crt_timing_core #(.HW(HW), .RW(RW), .SW(SW)) dut (
    .clk(clk), .rst(rst),
    .cfg_h_total(cfg_h_total), .cfg_h_disp(cfg_h_disp),
    .cfg_hs_start(cfg_hs_start), .cfg_hs_width(cfg_hs_width),
    .cfg_v_rows(cfg_v_rows), .cfg_v_disp(cfg_v_disp),
    .cfg_row_lines(cfg_row_lines), .cfg_v_adj(cfg_v_adj),
    .cfg_vs_row(cfg_vs_row), .cfg_vs_lines(cfg_vs_lines),
    .cfg_dbl(cfg_dbl), .cfg_vs_two_early(cfg_vs_two_early),
    .de(de), .hsync(hsync), .vsync(vsync),
    .col_addr(col_addr), .row_addr(row_addr), .scan_addr(scan_addr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run_cfg(input int ht, input int hd, input int hss, input int hsw,
                         input int sl, input int vr, input int vd, input int adj,
                         input int vsr, input int vsl, input bit two, input bit dbl);
    int fl;
    int ls;
    int lead;
    cfg_h_total = HW'(ht); cfg_h_disp = HW'(hd);
    cfg_hs_start = HW'(hss); cfg_hs_width = HW'(hsw);
    cfg_row_lines = SW'(sl); cfg_v_rows = RW'(vr); cfg_v_disp = RW'(vd);
    cfg_v_adj = SW'(adj); cfg_vs_row = RW'(vsr); cfg_vs_lines = SW'(vsl);
    cfg_vs_two_early = two; cfg_dbl = dbl;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R1: origin while reset is held
    check("R1", "col in reset", int'(col_addr), 0);
    check("R1", "row in reset", int'(row_addr), 0);
    check("R1", "scan in reset", int'(scan_addr), 0);
    rst = 1'b0;
    fl = vr * sl + adj;
    ls = vsr * sl;
    lead = two ? 2 : 1;
    for (int k = 0; k < 2 * fl * ht; k++) begin
      int h, l, er, es, ecol;
      bit eadj, ede, ehs, evs, in_early;
      if (k != 0) begin
        @(posedge clk);
        @(negedge clk);
        #1;
      end
      h = k % ht;
      l = (k / ht) % fl;
      if (l < vr * sl) begin er = l / sl; es = l % sl; eadj = 1'b0; end
      else begin er = vr - 1; es = l - vr * sl; eadj = 1'b1; end
      ede = (h < hd) && (er < vd) && !eadj;
      ehs = (h >= hss) && (h < hss + hsw);
      in_early = (((l + 1) % fl) == ls) && (h + lead >= ht);
      evs = (vsl != 0) && ((((l - ls + fl) % fl) < vsl) || in_early);
      ecol = dbl ? 2 * h : h;
      if (k == 0) check("R1", "col after reset", int'(col_addr), 0);
      check(dbl ? "R11" : "R2", "col_addr", int'(col_addr), ecol);
      check(eadj ? "R6" : "R5", "row_addr", int'(row_addr), er);
      check(eadj ? "R6" : "R5", "scan_addr", int'(scan_addr), es);
      check("R3", "de", int'(de), int'(ede));
      check("R4", "hsync", int'(hsync), int'(ehs));
      if (vsl == 0)      check("R10", "vsync", int'(vsync), int'(evs));
      else if (in_early) check(two ? "R9" : "R8", "vsync early rise", int'(vsync), int'(evs));
      else               check("R7", "vsync", int'(vsync), int'(evs));
    end
  endtask

  initial begin
    // adjust lines, one-clock lead, single width
    run_cfg(10, 6, 7, 2, 3, 6, 4, 2, 4, 4, 1'b0, 1'b0);
    // no adjust, vsync at row 0 across frame wrap, two-clock lead, double width
    run_cfg(10, 6, 7, 2, 3, 6, 4, 0, 0, 2, 1'b1, 1'b1);
    // zero-length vsync
    run_cfg(10, 6, 7, 2, 3, 6, 4, 1, 2, 0, 1'b0, 1'b0);
    // 25 of 50 rows, 8 lines each, vsync at row 37 for 16 lines
    run_cfg(8, 5, 6, 1, 8, 50, 25, 0, 37, 16, 1'b1, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule